// File: doc/BRIEF.md
# Gated Pulse Duration Timer

This block times how long a digital line rests at a chosen logic level, in microsecond units, and gives up once a programmed timeout elapses. A one-cycle start request loads the level of interest and the timeout. If the line is already at that level, counting begins straight away. Otherwise the block first waits for the line to arrive at that level and then counts for as long as it stays there.

The outcome appears on a signed result port, qualified by a one-cycle valid strobe. A non-negative value is the measured width in microseconds. A value of -2 means the line never reached the requested level before the timeout. A value of -1 means the line stayed at the level past the timeout. The block contains its own two-stage input synchroniser and a clock divider that makes the microsecond tick. A start request that arrives while a measurement is in progress is dropped.

Top module: `pdt_timer`

## Requirements
- R1: After reset, busy_o and valid_o are 0 and result_o is 0.
- R2: sig_i passes through two flip-flops before any level comparison, so a change on sig_i affects the block's decisions no earlier than the third rising edge after it.
- R3: The microsecond tick fires once every CLK_PER_US clock cycles, counted from reset.
- R4: In idle, a start_i pulse loads level_i and timeout_i and raises busy_o on the next cycle. If the synchronised input already equals level_i, the block begins measuring with no wait phase.
- R5: If the synchronised input differs from the selected level at start, the block waits until it matches, then begins measuring.
- R6: If the number of ticks seen in the wait phase reaches the timeout, the result is -2 (0xFFFFFFFE).
- R7: If the number of ticks seen in the measurement phase reaches the timeout, the result is -1 (0xFFFFFFFF).
- R8: The tick count restarts from zero when measurement begins. When the synchronised input leaves the selected level, the result is the non-negative number of ticks counted during measurement.
- R9: valid_o is a one-cycle strobe. busy_o falls on the same edge that raises valid_o, and result_o holds its value between strobes.
- R10: A start_i received while busy_o is 1 is ignored. The running measurement keeps its original level and timeout.
- R11: A timeout of 0 ends the current phase on its first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, one cycle; loads level_i and timeout_i |
| level_i | input | 1 | Level to time: 0 = low pulse, 1 = high pulse |
| timeout_i | input | TMO_W (31) | Timeout in microseconds, shared by both phases |
| sig_i | input | 1 | Asynchronous line being measured |
| busy_o | output | 1 | Measurement in progress |
| valid_o | output | 1 | One-cycle strobe qualifying result_o |
| result_o | output | TMO_W+1 (32) | Signed width in ticks, or -2 / -1 timeout code |

## Verification
The assertions assume that start_i is a synchronous pulse and that timeout_i and level_i are stable while start_i is high. They also assume that CLK_PER_US matches the divider the checker is bound with. The stimulus drives every input on the falling clock edge, so these conditions always hold. Meanwhile sig_i is moved freely, including at the same edge as start_i, to exercise the synchroniser latency. Each outcome code is reached: wait timeout, measurement timeout, immediate start, zero timeout, a start ignored while busy, and a wait that uses up most of the timeout before a short valid pulse.

// File: rtl/pdt_pkg.sv
// Package: shared types for the pulse duration timer.
// Assumes nothing beyond a single clock domain for its users.
package pdt_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_MEAS = 2'd2
    } phase_t;
endpackage

// File: rtl/pdt_sync.sv
// Module: pdt_sync
// Multi-stage synchroniser for one asynchronous bit.
// Assumes STAGES >= 2; the output lags the input by STAGES clocks.
module pdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw input in the first stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                // Shift through the following stages
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdt_tick_gen.sv
// Module: pdt_tick_gen
// Free-running divider producing a one-cycle tick every DIV clocks.
// Assumes DIV >= 1; the first tick comes DIV cycles after reset.
module pdt_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    // Count clock cycles, wrapping after the tick cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pdt_phase_ctl.sv
// Module: pdt_phase_ctl
// Wait / measure controller with shared timeout and signed result.
// Assumes sig_s_i is already synchronised and tick_i is a one-cycle enable.
module pdt_phase_ctl
    import pdt_pkg::*;
#(
    parameter int TMO_W = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               level_i,
    input  logic [TMO_W-1:0]   timeout_i,
    input  logic               sig_s_i,
    input  logic               tick_i,
    output logic               busy_o,
    output logic               valid_o,
    output logic [TMO_W:0]     result_o
);
    localparam int RES_W = TMO_W + 1;
    localparam logic [RES_W-1:0] CODE_WAIT_TMO = {{(RES_W-1){1'b1}}, 1'b0};
    localparam logic [RES_W-1:0] CODE_MEAS_TMO = {RES_W{1'b1}};

    phase_t             phase_q;
    logic               lvl_q;
    logic [TMO_W-1:0]   tmo_q;
    logic [TMO_W-1:0]   elapsed_q;
    logic [TMO_W:0]     next_cnt;
    logic               hit_limit;
    logic               at_level;

    assign next_cnt  = {1'b0, elapsed_q} + 1'b1;
    assign hit_limit = next_cnt >= {1'b0, tmo_q};
    assign at_level  = (sig_s_i == lvl_q);
    assign busy_o    = (phase_q != PH_IDLE);

    // Phase sequencing, tick counting and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            lvl_q     <= 1'b0;
            tmo_q     <= '0;
            elapsed_q <= '0;
            valid_o   <= 1'b0;
            result_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        lvl_q     <= level_i;
                        tmo_q     <= timeout_i;
                        elapsed_q <= '0;
                        phase_q   <= (sig_s_i == level_i) ? PH_MEAS : PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (at_level) begin
                        elapsed_q <= '0;
                        phase_q   <= PH_MEAS;
                    end else if (tick_i) begin
                        if (hit_limit) begin
                            result_o <= CODE_WAIT_TMO;
                            valid_o  <= 1'b1;
                            phase_q  <= PH_IDLE;
                        end else begin
                            elapsed_q <= next_cnt[TMO_W-1:0];
                        end
                    end
                end
                PH_MEAS: begin
                    if (!at_level) begin
                        result_o <= {1'b0, elapsed_q};
                        valid_o  <= 1'b1;
                        phase_q  <= PH_IDLE;
                    end else if (tick_i) begin
                        if (hit_limit) begin
                            result_o <= CODE_MEAS_TMO;
                            valid_o  <= 1'b1;
                            phase_q  <= PH_IDLE;
                        end else begin
                            elapsed_q <= next_cnt[TMO_W-1:0];
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pdt_timer.sv
// Module: pdt_timer
// Top of the gated pulse duration timer: synchroniser, tick divider
// and phase controller. Assumes one clock, synchronous active-low reset,
// and CLK_PER_US clock cycles per microsecond.
module pdt_timer #(
    parameter int CLK_PER_US  = 4,
    parameter int TMO_W       = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             level_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic             sig_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [TMO_W:0]   result_o
);
    localparam int RES_W = TMO_W + 1;

    logic sig_s_w;
    logic tick_w;

    pdt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sig_i),
        .q_o   (sig_s_w)
    );

    pdt_tick_gen #(.DIV(CLK_PER_US)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    pdt_phase_ctl #(.TMO_W(TMO_W)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .level_i   (level_i),
        .timeout_i (timeout_i),
        .sig_s_i   (sig_s_w),
        .tick_i    (tick_w),
        .busy_o    (busy_o),
        .valid_o   (valid_o),
        .result_o  (result_o)
    );
endmodule

// File: rtl/pdt_timer_chk.sv
// Module: pdt_timer_chk
// Assertion checker bound to pdt_timer. Assumes start_i is synchronous.
module pdt_timer_chk #(
    parameter int CLK_PER_US = 4,
    parameter int RES_W      = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             valid_o,
    input logic [RES_W-1:0] result_o,
    input logic             tick
);
    int unsigned gap_q;

    // Count cycles since the previous tick
    always_ff @(posedge clk) begin
        if (!rst_n)    gap_q <= 0;
        else if (tick) gap_q <= 0;
        else           gap_q <= gap_q + 1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == CLK_PER_US - 1)); // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R4
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($signed(result_o) >= -2)); // R8
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> valid_o); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o)); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || valid_o)); // R10
endmodule

bind pdt_timer pdt_timer_chk #(
    .CLK_PER_US (CLK_PER_US),
    .RES_W      (RES_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .result_o (result_o),
    .tick     (tick_w)
);

// File: tb/pdt_timer_tb.sv
// Bench for pdt_timer: behavioural reference compared every clock,
// plus directed checks on each outcome code.
module pdt_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int TW         = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          level_i = 1'b0;
    logic [TW-1:0] timeout_i = '0;
    logic          sig_i = 1'b0;
    logic          busy_o, valid_o;
    logic [TW:0]   result_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdt_timer #(.CLK_PER_US(DIV), .TMO_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
        .timeout_i(timeout_i), .sig_i(sig_i), .busy_o(busy_o),
        .valid_o(valid_o), .result_o(result_o)
    );

    // Behavioural reference: a queue stands for the synchroniser
    bit     q_sync[$];
    int     m_div, m_phase, m_el, m_tmo;
    bit     m_lvl, m_valid;
    longint m_res;

    always @(posedge clk) begin
        bit ss, tk;
        ss = q_sync[0];
        tk = (m_div == DIV - 1);
        if (!rst_n) begin
            q_sync = '{0, 0};
            m_div = 0; m_phase = 0; m_el = 0; m_tmo = 0;
            m_lvl = 0; m_valid = 0; m_res = 0;
        end else begin
            m_valid = 0;
            if (m_phase == 0) begin
                if (start_i) begin
                    m_lvl = level_i; m_tmo = int'(timeout_i); m_el = 0;
                    m_phase = (ss == level_i) ? 2 : 1;
                end
            end else if (ss == m_lvl && m_phase == 1) begin
                m_phase = 2; m_el = 0;
            end else if (ss != m_lvl && m_phase == 2) begin
                m_res = m_el; m_valid = 1; m_phase = 0;
            end else if (tk) begin
                if (m_el + 1 >= m_tmo) begin
                    m_res = (m_phase == 1) ? -2 : -1;
                    m_valid = 1; m_phase = 0;
                end else m_el++;
            end
            void'(q_sync.pop_front());
            q_sync.push_back(sig_i);
            m_div = tk ? 0 : m_div + 1;
        end
    end

    // Compare with the reference away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (busy_o !== (m_phase != 0) || valid_o !== m_valid ||
                (m_valid && $signed(result_o) != m_res)) begin
                n_bad++;
                $display("FAIL R2/R3/R9 cycle compare: busy=%0b valid=%0b res=%0d exp busy=%0b valid=%0b res=%0d",
                         busy_o, valid_o, $signed(result_o), m_phase != 0, m_valid, m_res);
            end
        end
    end

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go(input bit lvl, input int tmo);
        @(negedge clk);
        start_i = 1'b1; level_i = lvl; timeout_i = TW'(tmo);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_res(output longint r);
        r = 99;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (valid_o) begin r = $signed(result_o); break; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        longint r;
        idle(3);
        check("R1 busy", busy_o == 0, busy_o, 0);
        check("R1 valid", valid_o == 0, valid_o, 0);
        check("R1 result", result_o == 0, result_o, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R5 wait then high pulse of 30 cycles
        go(1, 100);
        check("R4 busy after start", busy_o == 1, busy_o, 1);
        idle(10); sig_i = 1; idle(30); sig_i = 0;
        wait_res(r);
        check("R5 width ticks", r >= 6 && r <= 8, r, 7);
        idle(5);

        // R4 already at level: no wait
        sig_i = 1; idle(5);
        go(1, 100); idle(20); sig_i = 0;
        wait_res(r);
        check("R4 immediate width", r >= 5 && r <= 7, r, 6);
        idle(5);

        // R6 wait timeout
        go(1, 3);
        wait_res(r);
        check("R6 wait timeout code", r == -2, r, -2);
        idle(3);

        // R7 measurement timeout
        sig_i = 1; idle(4);
        go(1, 5);
        wait_res(r);
        check("R7 meas timeout code", r == -1, r, -1);
        sig_i = 0; idle(4);

        // R8 low pulse with level 0
        sig_i = 1; idle(4);
        go(0, 50); idle(6); sig_i = 0; idle(16); sig_i = 1;
        wait_res(r);
        check("R8 low pulse width", r >= 3 && r <= 5, r, 4);
        idle(4);

        // R11 zero timeout ends at first tick
        go(1, 0);
        wait_res(r);
        check("R11 zero timeout", r == -1, r, -1);
        sig_i = 0; idle(4);

        // R10 start while busy ignored
        go(1, 3); idle(2);
        start_i = 1; level_i = 0; timeout_i = TW'(90);
        @(negedge clk) start_i = 0;
        check("R10 still busy", busy_o == 1, busy_o, 1);
        wait_res(r);
        check("R10 original config kept", r == -2, r, -2);
        idle(4);

        // R8 counter restarts when measuring begins
        go(1, 6); idle(16); sig_i = 1; idle(12); sig_i = 0;
        wait_res(r);
        check("R8 restart from zero", r >= 2 && r <= 4, r, 3);
        idle(4);

        // R2 sig raised at the start edge: not seen, so wait first
        @(negedge clk);
        start_i = 1; level_i = 1; timeout_i = TW'(40); sig_i = 1;
        @(negedge clk) start_i = 0;
        idle(40); sig_i = 0;
        wait_res(r);
        check("R2 sync latency width", r >= 9 && r <= 10, r, 10);
        idle(4);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule